// File: doc/BRIEF.md
# Dual-Rail Array Multiplier with Completion Detection

This block multiplies two unsigned 16-bit operands without any clock. Every operand bit, every internal partial-product and sum bit, and every product bit travels on a pair of wires. One wire is the true rail and the other is the false rail. A pair with both wires low is the empty spacer. A pair with only the false rail high carries logic 0, and a pair with only the true rail high carries logic 1. A pair with both rails high is illegal.

Each partial product is formed by a dual-rail AND cell. The partial products are summed by a right-to-left array of dual-rail full adders. In this array each adder hands its sum down to the next row and its carry left to the next bit in its own row. The last row finishes the upper half of the product. A completion detector raises `done` once all 32 product pairs hold a valid code.

The block is used in four-phase fashion. The producer drives valid operand codes and waits for `done`. It then returns every operand pair to empty and waits for `done` to fall before presenting the next pair.

Top module: `dr_array_mult`

## Requirements
- R1: When every operand pair is valid, the product decoded from the true rails equals the unsigned product of the decoded operands, and each product false rail is the complement of its true rail.
- R2: `done` is high exactly when every one of the 32 product pairs holds a valid code.
- R3: As long as no operand pair is (1,1), no product pair ever shows both rails high.
- R4: When all operand pairs are empty, all product pairs are empty and `done` is low.
- R5: When all operand pairs are valid, `done` is high after the array settles, with no clock involved.
- R6: `done` stays low while any operand bit is still empty. This holds while operand bits arrive one at a time in any order, and again while they return to empty one at a time.
- R7: With a partly valid operand set, every product pair that is already valid carries the value it will hold once all operands are valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_t | input | 16 | Multiplicand, true rails |
| a_f | input | 16 | Multiplicand, false rails |
| b_t | input | 16 | Multiplier, true rails |
| b_f | input | 16 | Multiplier, false rails |
| p_t | output | 32 | Product, true rails |
| p_f | output | 32 | Product, false rails |
| done | output | 1 | Completion: all product pairs valid |

## Verification
A spacer constant that is wrongly tied valid, or a full-adder rail with a term missing, shows up at the ports in one of three ways. Product pairs may turn valid while the operands are still empty. Pairs may carry a wrong value during a partial arrival. `done` may rise before the last operand bit has landed. All of these are visible in the same cycle as the operand change that exposes them, because the path is purely combinational. Releasing operand bits one at a time in random order puts the block through a long run of partial states. Withdrawing them one at a time does the same for the return to empty, and each of these states is compared against a behavioural model.

// File: rtl/dr_array_mult.sv
module dr_array_mult #(
  parameter int W = 16,
  localparam int PW = 2 * W
) (
  input  logic [W-1:0]  a_t,
  input  logic [W-1:0]  a_f,
  input  logic [W-1:0]  b_t,
  input  logic [W-1:0]  b_f,
  output logic [PW-1:0] p_t,
  output logic [PW-1:0] p_f,
  output logic          done
);

  logic [W-1:0] pp_t [W];
  logic [W-1:0] pp_f [W];
  logic [W:0]   r_t  [W];
  logic [W:0]   r_f  [W];

  for (genvar i = 0; i < W; i++) begin : g_pp
    for (genvar j = 0; j < W; j++) begin : g_bit
      assign pp_t[i][j] = a_t[j] & b_t[i];
      assign pp_f[i][j] = (a_f[j] & (b_f[i] | b_t[i])) | (a_t[j] & b_f[i]);
    end
  end

  assign r_t[0] = {1'b0, pp_t[0]};
  assign r_f[0] = {b_t[0] | b_f[0], pp_f[0]};

  for (genvar i = 1; i < W; i++) begin : g_row
    logic [W:0] ct, cf;
    assign ct[0] = 1'b0;
    assign cf[0] = b_t[i] | b_f[i];
    for (genvar j = 0; j < W; j++) begin : g_fa
      logic xt, xf, yt, yf;
      assign xt = pp_t[i][j];
      assign xf = pp_f[i][j];
      assign yt = r_t[i-1][j+1];
      assign yf = r_f[i-1][j+1];
      assign cf[j+1] = (xf & yf) | (xf & cf[j]) | (yf & cf[j]);
      assign ct[j+1] = (xt & yt) | (xt & ct[j]) | (yt & ct[j]);
      assign r_f[i][j] = (xf & yf & cf[j]) | (xt & yt & cf[j]) |
                         (xf & yt & ct[j]) | (xt & yf & ct[j]);
      assign r_t[i][j] = (xt & yt & ct[j]) | (xt & yf & cf[j]) |
                         (xf & yt & cf[j]) | (xf & yf & ct[j]);
    end
    assign r_t[i][W] = ct[W];
    assign r_f[i][W] = cf[W];
  end

  for (genvar i = 0; i < W - 1; i++) begin : g_lo
    assign p_t[i] = r_t[i][0];
    assign p_f[i] = r_f[i][0];
  end
  assign p_t[PW-1:W-1] = r_t[W-1];
  assign p_f[PW-1:W-1] = r_f[W-1];

  assign done = &(p_t | p_f);

  logic in_legal, in_valid, in_empty;
  assign in_legal = ((a_t & a_f) == '0) && ((b_t & b_f) == '0);
  assign in_valid = in_legal && (&(a_t | a_f)) && (&(b_t | b_f));
  assign in_empty = ((a_t | a_f | b_t | b_f) == '0);

  always_comb begin
    if (in_legal)
      a_r3_no_illegal: assert ((p_t & p_f) == '0)
        else $error("R3: product pair with both rails high");
    if (done && in_legal)
      a_r1_value: assert (p_t == ({{W{1'b0}}, a_t} * {{W{1'b0}}, b_t}))
        else $error("R1: completed product value wrong");
    if (in_empty)
      a_r4_spacer: assert (p_t == '0 && p_f == '0 && !done)
        else $error("R4: spacer not propagated");
    if (in_valid)
      a_r5_complete: assert (done)
        else $error("R5: done low with valid operands");
    if (done)
      a_r6_no_early_done: assert ((&(a_t | a_f)) && (&(b_t | b_f)))
        else $error("R6: done with an empty operand bit");
  end

endmodule

// File: tb/sim_dr_array_mult.sv
module sim_dr_array_mult;
  localparam int W = 16;
  localparam int PW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [W-1:0] tgt_a = '0, tgt_b = '0, msk_a = '0, msk_b = '0;
  logic [W-1:0] a_t, a_f, b_t, b_f;
  logic [PW-1:0] p_t, p_f;
  logic done;

  assign a_t = tgt_a & msk_a;
  assign a_f = ~tgt_a & msk_a;
  assign b_t = tgt_b & msk_b;
  assign b_f = ~tgt_b & msk_b;

  dr_array_mult #(.W(W)) u0 (
    .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
    .p_t(p_t), .p_f(p_f), .done(done)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [PW-1:0] exp_p;
    bit all_v, all_e;
    if (!rst) begin
      exp_p = {{W{1'b0}}, tgt_a} * {{W{1'b0}}, tgt_b};
      all_v = (&msk_a) && (&msk_b);
      all_e = (msk_a == '0) && (msk_b == '0);
      chk((p_t & p_f) == '0, "R3 illegal pair", p_t & p_f, 32'h0);
      chk(done == (&(p_t | p_f)), "R2 done vs pairs", {31'h0, done}, {31'h0, &(p_t | p_f)});
      if (all_v) begin
        chk(p_t == exp_p, "R1 product true rails", p_t, exp_p);
        chk(p_f == ~exp_p, "R1 product false rails", p_f, ~exp_p);
        chk(done, "R5 done with valid operands", {31'h0, done}, 32'h1);
      end else if (all_e) begin
        chk(p_t == '0 && p_f == '0, "R4 spacer product", p_t | p_f, 32'h0);
        chk(!done, "R4 done low on spacer", {31'h0, done}, 32'h0);
      end else begin
        chk(!done, "R6 done low with empty operand bit", {31'h0, done}, 32'h0);
        chk((p_t & ~exp_p) == '0 && (p_f & exp_p) == '0, "R7 early bits consistent",
            p_t, exp_p);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #1;
  endtask

  task automatic full_pair(input logic [W-1:0] x, input logic [W-1:0] y);
    msk_a = '0; msk_b = '0;
    wait_cyc(2);
    tgt_a = x; tgt_b = y;
    msk_a = '1; msk_b = '1;
    wait_cyc(2);
    msk_a = '0; msk_b = '0;
    wait_cyc(1);
  endtask

  task automatic stagger(input logic [W-1:0] x, input logic [W-1:0] y, input bit rise);
    logic [2*W-1:0] m;
    m = rise ? '0 : '1;
    tgt_a = x; tgt_b = y;
    {msk_a, msk_b} = m;
    wait_cyc(1);
    for (int k = 0; k < 2 * W; k++) begin
      int idx;
      idx = int'($urandom % (2 * W));
      while (m[idx] == rise) idx = (idx + 1) % (2 * W);
      m[idx] = rise;
      {msk_a, msk_b} = m;
      wait_cyc(1);
    end
  endtask

  initial begin
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(2);
    full_pair(16'h0000, 16'h0000);
    full_pair(16'hffff, 16'hffff);
    full_pair(16'h0001, 16'habcd);
    full_pair(16'h8000, 16'h8000);
    full_pair(16'hffff, 16'h0001);
    full_pair(16'h5555, 16'haaaa);
    for (int n = 0; n < 40; n++) full_pair(16'($urandom), 16'($urandom));
    for (int n = 0; n < 6; n++) begin
      logic [W-1:0] x, y;
      x = (n == 0) ? 16'hffff : 16'($urandom);
      y = (n == 0) ? 16'hffff : 16'($urandom);
      stagger(x, y, 1'b1);
      stagger(x, y, 1'b0);
    end
    wait_cyc(2);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule